// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus transfer at a time over a bus whose lines carry first an address and then data. Each transfer starts from a request accepted while the sequencer is idle. The request supplies the address, the direction (read or write), the space (memory or I/O), the width (byte or word) and, for writes, the data. The sequencer then steps through the states T1, T2, T3, zero or more wait states (TW) and T4, one state per clock. In each state it drives the shared lines, their output enable and the bus strobes. The data-enable strobe also moves at the middle of a clock.

The ready input passes through a two-stage synchronizer. While the synchronized ready is low at the end of T3 or of a wait state, the sequencer adds another wait state. On a read, the word on the bus is captured and presented together with a one-state done pulse. When another master asks for the bus, the idle sequencer turns off the drivers of the shared lines and of the read and space strobes until the bus is handed back.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ad_oe` is high and `ad_out` carries the captured address. From T2 through T4, a write drives the write data, zero-extended, with `ad_oe` high, and a read keeps `ad_oe` low.
- R2: `ale` is high during exactly T1 of every transfer and low at all other times.
- R3: `rd_n` is low during T2, T3 and every wait state of a read and high otherwise. `wr_n` behaves the same way for a write.
- R4: For a read, `den_n` falls at the middle of T2 and rises at the middle of T4.
- R5: For a write, `den_n` falls at the start of T2 and rises at the middle of T4.
- R6: `dt_r` (1 = send, 0 = receive) and `m_io` (1 = memory, 0 = I/O) follow the request captured at acceptance for the whole transfer. Changes on the request inputs after acceptance have no effect.
- R7: In T1, `bhe_n` is 0 for a word or for a byte at an odd address, and 1 for a byte at an even address. Outside T1 it is 1.
- R8: `ready_in` is synchronized through two flops. A synchronized low at the end of T3 or TW leads to another TW, and a synchronized high leads to T4. Ready dropped during T1 and raised during the state with index N (T1 = 0) gives exactly N wait states.
- R9: `rd_data` captures `ad_in` at the clock edge that ends the last state before T4. `done` is high during T4 only.
- R10: A request is accepted only in the idle state. While idle, `ale` is low and `rd_n`, `wr_n` and `den_n` are high.
- R11: In idle, `bus_release` high takes priority over a request. From the next clock on, `ad_oe` and `ctl_oe` are low and requests are ignored, until the clock after `bus_release` falls.
- R12: During reset, `ale`, `ad_oe` and `done` are low, and `rd_n`, `wr_n`, `den_n`, `bhe_n` and `ctl_oe` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request, sampled while idle |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | DATA_W | Write data |
| bus_release | input | 1 | Another master asks for the bus |
| ready_in | input | 1 | Asynchronous ready from the addressed device |
| ad_in | input | DATA_W | Data read back from the shared lines |
| ad_out | output | ADDR_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Enable for the shared-line drivers |
| ctl_oe | output | 1 | Enable for the rd_n and m_io drivers |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | High bank enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Space select |
| dt_r | output | 1 | Transceiver direction |
| den_n | output | 1 | Transceiver enable, active low |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | High for the T4 state |

## Verification
A wrong state in the sequencer shows up on the strobes in the same clock: a missing or extra wait state moves the rise of `rd_n` or `wr_n` and the done pulse by one clock. A wrong half-clock state moves the `den_n` edges by half a clock. The bench therefore samples every output at both the quarter and the three-quarter point of each state. A read captured on the wrong edge shows as a wrong `rd_data` in T4, because the bench changes `ad_in` just before and just after the capture edge.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;

  // States in which the direction strobe is asserted
  function automatic logic strobe_state(bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // States that may end with the ready decision
  function automatic logic decide_state(bus_st_e s);
    return (s == ST_T3) || (s == ST_TW);
  endfunction

  // High bank enable (active low) from width and address bit 0
  function automatic logic bank_hi_n(logic word, logic a0);
    return !(word || a0);
  endfunction

endpackage

// File: rtl/busseq_sync.sv
module busseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    bus_release,
  input  logic    rdy_s,
  output bus_st_e st,
  output logic    ev_accept,
  output logic    ev_wait,
  output logic    ev_latch
);
  bus_st_e st_nx;

  assign ev_accept = (st == ST_IDLE) && !bus_release && req_valid;
  assign ev_wait   = decide_state(st) && !rdy_s;
  assign ev_latch  = decide_state(st) && rdy_s;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (bus_release) st_nx = ST_HOLD;
               else if (req_valid) st_nx = ST_T1;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_T3,
      ST_TW:   st_nx = rdy_s ? ST_T4 : ST_TW;
      ST_T4:   st_nx = ST_IDLE;
      ST_HOLD: if (!bus_release) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/busseq_drive.sv
module busseq_drive
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           st,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              cur_write,
  input  logic              cur_mem,
  input  logic              cur_word,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ctl_oe,
  output logic              ale,
  output logic              bhe_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n
);
  // State as seen from the falling edge: lags st by half a clock
  bus_st_e half_st;
  logic    data_phase;
  logic    rd_en_act;
  logic    wr_en_act;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_st <= ST_IDLE;
    else        half_st <= st;
  end

  assign data_phase = strobe_state(st) || (st == ST_T4);
  assign rd_en_act  = strobe_state(half_st);
  assign wr_en_act  = strobe_state(st) || ((st == ST_T4) && strobe_state(half_st));

  always_comb begin
    ad_out = '0;
    if (st == ST_T1)                   ad_out = cur_addr;
    else if (cur_write && data_phase)  ad_out[DATA_W-1:0] = cur_wdata;
  end

  assign ad_oe  = (st == ST_T1) || (cur_write && data_phase);
  assign ctl_oe = (st != ST_HOLD);
  assign ale    = (st == ST_T1);
  assign bhe_n  = (st == ST_T1) ? bank_hi_n(cur_word, cur_addr[0]) : 1'b1;
  assign rd_n   = !(!cur_write && strobe_state(st));
  assign wr_n   = !(cur_write && strobe_state(st));
  assign m_io   = cur_mem;
  assign dt_r   = cur_write;
  assign den_n  = !(cur_write ? wr_en_act : rd_en_act);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import busseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_release,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ctl_oe,
  output logic              ale,
  output logic              bhe_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  bus_st_e           st;
  logic              rdy_s;
  logic              ev_accept;
  logic              ev_wait;
  logic              ev_latch;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;
  logic              cur_mem;
  logic              cur_word;

  busseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ready_in), .q(rdy_s)
  );

  busseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_release(bus_release),
    .rdy_s(rdy_s), .st(st), .ev_accept(ev_accept), .ev_wait(ev_wait),
    .ev_latch(ev_latch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      cur_mem   <= 1'b1;
      cur_word  <= 1'b0;
    end else if (ev_accept) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_write <= req_write;
      cur_mem   <= req_mem;
      cur_word  <= req_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (ev_latch) rd_data <= ad_in;
  end

  assign done = (st == ST_T4);

  busseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .st(st), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_write(cur_write), .cur_mem(cur_mem), .cur_word(cur_word),
    .ad_out(ad_out), .ad_oe(ad_oe), .ctl_oe(ctl_oe), .ale(ale), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n)
  );
endmodule

// File: rtl/busseq_chk.sv
module busseq_chk
  import busseq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input bus_st_e st,
  input logic    rdy_s,
  input logic    ev_accept,
  input logic    ev_wait,
  input logic    bus_release,
  input logic    ale,
  input logic    rd_n,
  input logic    wr_n,
  input logic    ad_oe,
  input logic    ctl_oe,
  input logic    done
);
  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r8_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait |=> (st == ST_TW) && (!rd_n || !wr_n));

  a_r8_t4_high: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_state(st) && rdy_s) |=> done);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> ale);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (rd_n && wr_n && !ale && !done));

  a_r11_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && bus_release) |=> (!ad_oe && !ctl_oe && !ale));
endmodule

bind mux_bus_seq busseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .rdy_s(rdy_s), .ev_accept(ev_accept),
  .ev_wait(ev_wait), .bus_release(bus_release), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .ctl_oe(ctl_oe), .done(done)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic          mem;
    logic          word;
    logic [DW-1:0] wdata;
    logic [3:0]    nwait;
    logic [DW-1:0] rdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{20'h12340, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd0, 16'hBEEF},
    '{20'h24451, 1'b1, 1'b1, 1'b0, 16'h00A5, 4'd2, 16'h0000},
    '{20'h00088, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h1234},
    '{20'hFFFFE, 1'b1, 1'b1, 1'b1, 16'hCAFE, 4'd0, 16'h0000},
    '{20'h30007, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3, 16'h5A5A},
    '{20'h00002, 1'b1, 1'b0, 1'b0, 16'h0077, 4'd1, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_mem = 1'b0;
  logic          req_word = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          bus_release = 1'b0;
  logic          ready_in = 1'b1;
  logic [DW-1:0] ad_in = '0;
  logic [AW-1:0] ad_out;
  logic          ad_oe, ctl_oe, ale, bhe_n, rd_n, wr_n, m_io, dt_r, den_n, done;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mem(req_mem), .req_word(req_word),
    .req_wdata(req_wdata), .bus_release(bus_release), .ready_in(ready_in),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ctl_oe(ctl_oe), .ale(ale),
    .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r),
    .den_n(den_n), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Advance to the quarter point of the next clock
  task automatic to_q();
    @(posedge clk);
    #5;
  endtask

  task automatic idle_quiet(input string tag);
    chk({tag, " R10 ale"}, ale, 0);
    chk({tag, " R10 rd_n"}, rd_n, 1);
    chk({tag, " R10 wr_n"}, wr_n, 1);
    chk({tag, " R10 den_n"}, den_n, 1);
    chk({tag, " R9 done"}, done, 0);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    n = int'(v.nwait);
    req_addr  = v.addr;
    req_write = v.wr;
    req_mem   = v.mem;
    req_word  = v.word;
    req_wdata = v.wdata;
    req_valid = 1'b1;
    ready_in  = 1'b1;
    ad_in     = ~v.rdata;
    for (int i = 0; i <= 3 + n; i++) begin
      logic [AW-1:0] exp_ad;
      logic          strb, den_e1, den_e2;
      to_q();
      if (n > 0 && i == 0) ready_in = 1'b0;
      if (n > 0 && i == n) ready_in = 1'b1;
      if (i == 1) begin
        // R6: request inputs change after acceptance
        req_write = ~v.wr;
        req_mem   = ~v.mem;
        req_word  = ~v.word;
      end
      if (i == 2 + n) ad_in = v.rdata;
      strb   = (i >= 1) && (i <= 2 + n);
      exp_ad = (i == 0) ? v.addr : {{(AW-DW){1'b0}}, v.wdata};
      den_e1 = v.wr ? !(i >= 1) : !(i >= 2);
      den_e2 = !strb;
      chk("R2 ale", ale, (i == 0));
      chk("R1 ad_oe", ad_oe, (i == 0) || v.wr);
      if ((i == 0) || v.wr) chk("R1 ad_out", ad_out, exp_ad);
      chk("R3 rd_n", rd_n, !(!v.wr && strb));
      chk("R3 wr_n", wr_n, !(v.wr && strb));
      chk("R7 bhe_n", bhe_n, (i == 0) ? !(v.word || v.addr[0]) : 1'b1);
      chk("R6 m_io", m_io, v.mem);
      chk("R6 dt_r", dt_r, v.wr);
      chk(v.wr ? "R5 den_n first half" : "R4 den_n first half", den_n, den_e1);
      chk("R9 R8 done", done, (i == 3 + n));
      if (i == 3 + n && !v.wr) chk("R9 rd_data", rd_data, v.rdata);
      if (i == 3 + n) begin
        ad_in = ~v.rdata;
        req_valid = 1'b0;
      end
      #10;
      chk(v.wr ? "R5 den_n second half" : "R4 den_n second half", den_n, den_e2);
      if (i == 3 + n && !v.wr) chk("R9 rd_data hold", rd_data, v.rdata);
    end
    to_q();
    idle_quiet("after cycle");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    chk("R12 ale", ale, 0);
    chk("R12 ad_oe", ad_oe, 0);
    chk("R12 done", done, 0);
    chk("R12 rd_n", rd_n, 1);
    chk("R12 wr_n", wr_n, 1);
    chk("R12 den_n", den_n, 1);
    chk("R12 bhe_n", bhe_n, 1);
    chk("R12 ctl_oe", ctl_oe, 1);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      to_q();
      idle_quiet("idle");
    end

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R11: release wins over a simultaneous request
    bus_release = 1'b1;
    req_valid   = 1'b1;
    req_write   = 1'b1;
    for (int k = 0; k < 3; k++) begin
      to_q();
      chk("R11 ctl_oe", ctl_oe, 0);
      chk("R11 ad_oe", ad_oe, 0);
      chk("R11 ale", ale, 0);
      chk("R11 wr_n", wr_n, 1);
    end
    bus_release = 1'b0;
    req_valid   = 1'b0;
    to_q();
    chk("R11 ctl_oe back", ctl_oe, 1);
    idle_quiet("after release");
    run_vec(VECS[2]);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule